// File: doc/BRIEF.md
# Amplitude Envelope Keyer

This block scales a pair of signed sample streams, one in-phase and one quadrature, by an unsigned scale factor, so that a burst of signal can be switched on and off with a controlled amplitude slope. Each output is the product of its sample and the scale factor shifted right by the scale width. The result comes out of a register one clock after the inputs. A global enable bypasses the multiplication, and the samples then pass through at full amplitude.

The scale factor has two sources. In automatic mode, an amplitude counter moves one step for every tick of a reloadable down-counter whose period is set by the rate word. A key input sets the direction: up to full scale while the key is high, down to zero while it is low. In manual mode, each channel takes its scale factor from its own programmed word. The amplitude counter is driven by a four-state machine. ENV_ZERO holds the amplitude at zero. ENV_RISE steps it up. ENV_FULL holds it at full scale. ENV_FALL steps it down. The transitions are: ZERO goes to RISE when the key is high. RISE goes to FALL when the key is low, and to FULL when the amplitude is at maximum. FULL goes to FALL when the key is low. FALL goes to RISE when the key is high, and to ZERO when the amplitude is zero.

Top module: `envelope_keyer`

## Requirements
- R1: When `env_en` is low, each output equals its sample input from the previous clock, with no scaling.
- R2: When `env_en` is high and `auto_mode` is low, `i_out` = floor(`i_in` × `man_scale_i` / 4096) and `q_out` = floor(`q_in` × `man_scale_q` / 4096). Samples are two's complement and scale words are unsigned. Each output appears one clock after its inputs.
- R3: When `env_en` and `auto_mode` are both high, both channels are scaled by the same internal amplitude value, using the R2 formula.
- R4: With a rate word n ≥ 3, the rate counter gives one tick every n+1 clocks. Reset loads the counter with n and clears the amplitude, so the first step lands on the (n+1)th clock edge after reset is released.
- R5: While the key is high, each tick raises the amplitude by one. The amplitude stops at 4095 and does not wrap.
- R6: While the key is low, each tick lowers the amplitude by one. The amplitude stops at 0 and does not wrap.
- R7: While the rate word is below 3, no ticks occur and the amplitude is frozen. Ticks resume once the word is 3 or more.
- R8: While `rst_n` is low, both outputs are forced to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| env_en | input | 1 | 1 = apply scaling, 0 = bypass |
| auto_mode | input | 1 | 1 = ramp amplitude, 0 = manual scale words |
| key_in | input | 1 | Ramp direction: 1 = up, 0 = down |
| rate_word | input | 8 | Rate counter reload value n |
| man_scale_i | input | 12 | Manual scale for the I channel |
| man_scale_q | input | 12 | Manual scale for the Q channel |
| i_in | input | 12 | Signed I sample |
| q_in | input | 12 | Signed Q sample |
| i_out | output | 12 | Scaled I sample, registered |
| q_out | output | 12 | Scaled Q sample, registered |

## Verification
The assertions assume that every input is driven to a known level at each clock edge. They also assume that reset is held low for at least one edge before checks begin, because the rate counter loads the live rate word during reset. The bench changes every input only at falling edges and holds reset for three edges. It takes the rate word below 3 and back again only while reset is high, which exercises the frozen condition without a partial reload.

// File: rtl/env_key_pkg.sv
package env_key_pkg;

    typedef enum logic [1:0] {
        ENV_ZERO = 2'd0,
        ENV_RISE = 2'd1,
        ENV_FULL = 2'd2,
        ENV_FALL = 2'd3
    } env_state_t;

endpackage

// File: rtl/env_rate_counter.sv
module env_rate_counter #(
    parameter int RW         = 8,
    parameter int MIN_RELOAD = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] reload_i,
    output logic          tick_o
);
    localparam logic [RW-1:0] MIN_R = RW'(MIN_RELOAD);

    logic [RW-1:0] cnt_q;
    logic          paused;

    assign paused = (reload_i < MIN_R);
    assign tick_o = !paused && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= reload_i;
        else if (paused)
            cnt_q <= cnt_q;
        else if (cnt_q == '0)
            cnt_q <= reload_i;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // R4: after a tick with a legal rate, the counter is reloaded, so no back-to-back ticks
    p_no_double_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !paused) |=> !tick_o);

    // R7: a paused counter does not move
    p_hold_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/env_ramp_fsm.sv
module env_ramp_fsm
    import env_key_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_i,
    input  logic          tick_i,
    output logic [AW-1:0] amp_o
);
    localparam logic [AW-1:0] AMP_MAX = {AW{1'b1}};
    localparam logic [AW-1:0] AMP_MIN = '0;

    env_state_t    state_q, state_d;
    logic [AW-1:0] amp_q, amp_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENV_ZERO: if (key_i) state_d = ENV_RISE;
            ENV_RISE: begin
                if (!key_i)              state_d = ENV_FALL;
                else if (amp_q == AMP_MAX) state_d = ENV_FULL;
            end
            ENV_FULL: if (!key_i) state_d = ENV_FALL;
            ENV_FALL: begin
                if (key_i)               state_d = ENV_RISE;
                else if (amp_q == AMP_MIN) state_d = ENV_ZERO;
            end
            default: state_d = ENV_ZERO;
        endcase
    end

    // amplitude stepping
    always_comb begin
        amp_d = amp_q;
        unique case (state_q)
            ENV_RISE: if (tick_i && amp_q != AMP_MAX) amp_d = amp_q + 1'b1;
            ENV_FALL: if (tick_i && amp_q != AMP_MIN) amp_d = amp_q - 1'b1;
            ENV_ZERO: amp_d = amp_q;
            ENV_FULL: amp_d = amp_q;
            default:  amp_d = amp_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENV_ZERO;
            amp_q   <= AMP_MIN;
        end else begin
            state_q <= state_d;
            amp_q   <= amp_d;
        end
    end

    // outputs
    always_comb begin
        amp_o = amp_q;
    end

    // R5: the amplitude moves by at most one step per clock
    p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_q != $past(amp_q)) |->
            ((amp_q == $past(amp_q) + 1'b1) || (amp_q == $past(amp_q) - 1'b1)));

    // R5: no wrap from full scale to zero
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_q == AMP_MAX) |=> (amp_q != AMP_MIN));

    // R6: no wrap from zero to full scale
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_q == AMP_MIN) |=> (amp_q != AMP_MAX));

    // R7: without a tick the amplitude stays put
    p_still_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(amp_q));

endmodule

// File: rtl/env_scaler.sv
module env_scaler #(
    parameter int DW = 12,
    parameter int SW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [SW-1:0]        scale_i,
    input  logic signed [DW-1:0] samp_i,
    output logic signed [DW-1:0] samp_o
);
    localparam int PW = DW + SW + 1;

    logic signed [PW-1:0] prod;
    logic signed [DW-1:0] scaled;

    assign prod   = samp_i * $signed({1'b0, scale_i});
    assign scaled = prod[DW+SW-1:SW];

    always_ff @(posedge clk) begin
        if (!rst_n)
            samp_o <= '0;
        else if (en_i)
            samp_o <= scaled;
        else
            samp_o <= samp_i;
    end

    // R1: bypass forwards the previous sample unchanged
    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (samp_o == $past(samp_i)));

    // R2: a zero scale yields zero output
    p_zero_scale_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && scale_i == '0) |=> (samp_o == '0));

endmodule

// File: rtl/envelope_keyer.sv
module envelope_keyer #(
    parameter int DW         = 12,
    parameter int AW         = 12,
    parameter int RW         = 8,
    parameter int MIN_RELOAD = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 env_en,
    input  logic                 auto_mode,
    input  logic                 key_in,
    input  logic [RW-1:0]        rate_word,
    input  logic [AW-1:0]        man_scale_i,
    input  logic [AW-1:0]        man_scale_q,
    input  logic signed [DW-1:0] i_in,
    input  logic signed [DW-1:0] q_in,
    output logic signed [DW-1:0] i_out,
    output logic signed [DW-1:0] q_out
);
    localparam int NCH = 2;

    logic                 tick;
    logic [AW-1:0]        amp;
    logic [AW-1:0]        man_scale [NCH];
    logic signed [DW-1:0] samp_in   [NCH];
    logic signed [DW-1:0] samp_out  [NCH];

    assign man_scale[0] = man_scale_i;
    assign man_scale[1] = man_scale_q;
    assign samp_in[0]   = i_in;
    assign samp_in[1]   = q_in;
    assign i_out        = samp_out[0];
    assign q_out        = samp_out[1];

    env_rate_counter #(.RW(RW), .MIN_RELOAD(MIN_RELOAD)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (rate_word),
        .tick_o   (tick)
    );

    env_ramp_fsm #(.AW(AW)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_i  (key_in),
        .tick_i (tick),
        .amp_o  (amp)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [AW-1:0] scale_sel;
        assign scale_sel = auto_mode ? amp : man_scale[ch];

        env_scaler #(.DW(DW), .SW(AW)) u_scale (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (env_en),
            .scale_i (scale_sel),
            .samp_i  (samp_in[ch]),
            .samp_o  (samp_out[ch])
        );
    end

    // R3: in ramp mode both channels see one amplitude, so equal inputs give equal outputs
    p_shared_amp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (env_en && auto_mode && i_in == q_in) |=> (i_out == q_out));

endmodule

// File: tb/tb_envelope_keyer.sv
module tb_envelope_keyer;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              env_en = 1'b0, auto_mode = 1'b0, key_in = 1'b0;
    logic [7:0]        rate_word = 8'd3;
    logic [11:0]       man_scale_i = '0, man_scale_q = '0;
    logic signed [11:0] i_in = '0, q_in = '0;
    logic signed [11:0] i_out, q_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    envelope_keyer dut (
        .clk(clk), .rst_n(rst_n), .env_en(env_en), .auto_mode(auto_mode),
        .key_in(key_in), .rate_word(rate_word), .man_scale_i(man_scale_i),
        .man_scale_q(man_scale_q), .i_in(i_in), .q_in(q_in),
        .i_out(i_out), .q_out(q_out)
    );

    // {en, auto, i, q, scale_i, scale_q, exp_i, exp_q}
    localparam logic [73:0] VEC [0:5] = '{
        {1'b0, 1'b0, 12'h064, 12'hFFB, 12'h000, 12'h000, 12'h064, 12'hFFB},
        {1'b1, 1'b0, 12'h7FF, 12'h800, 12'hFFF, 12'h800, 12'h7FE, 12'hC00},
        {1'b1, 1'b0, 12'h3E8, 12'hC18, 12'h000, 12'h000, 12'h000, 12'h000},
        {1'b1, 1'b0, 12'hFFF, 12'h190, 12'h400, 12'hC00, 12'hFFF, 12'h12C},
        {1'b1, 1'b0, 12'hC17, 12'h7FF, 12'h800, 12'h001, 12'hE0B, 12'h000},
        {1'b0, 1'b1, 12'h800, 12'h7FF, 12'h000, 12'h000, 12'h800, 12'h7FF}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R8: outputs held at zero during reset
        env_en = 1'b0; i_in = 12'sd321; q_in = -12'sd77;
        cycles(3);
        chk("R8 i_out in reset", int'(i_out), 0);
        chk("R8 q_out in reset", int'(q_out), 0);
        rst_n = 1'b1;

        // table walk: R1 bypass and R2 manual scaling
        key_in = 1'b1;
        for (int k = 0; k < 6; k++) begin
            env_en      = VEC[k][73];
            auto_mode   = VEC[k][72];
            i_in        = VEC[k][71:60];
            q_in        = VEC[k][59:48];
            man_scale_i = VEC[k][47:36];
            man_scale_q = VEC[k][35:24];
            cycles(1);
            chk(VEC[k][73] ? "R2 i_out" : "R1 i_out", int'(i_out), int'($signed(VEC[k][23:12])));
            chk(VEC[k][73] ? "R2 q_out" : "R1 q_out", int'(q_out), int'($signed(VEC[k][11:0])));
        end

        // ramp: rate 3, key high, I=2047, Q=-2048
        env_en = 1'b1; auto_mode = 1'b1; key_in = 1'b1; rate_word = 8'd3;
        i_in = 12'sd2047; q_in = -12'sd2048;
        do_reset();
        cycles(4);
        chk("R4 no step before n+1 edges", int'(q_out), 0);
        cycles(1);
        chk("R4 first step at edge n+1", int'(q_out), -1);
        cycles(36);
        chk("R3 q at amplitude 10", int'(q_out), -5);
        chk("R3 i at amplitude 10", int'(i_out), 4);
        cycles(16359);
        chk("R5 i at full scale", int'(i_out), 2046);
        chk("R5 q at full scale", int'(q_out), -2048);
        cycles(600);
        chk("R5 saturated at 4095", int'(i_out), 2046);
        key_in = 1'b0;
        cycles(5);
        chk("R6 first step down", int'(q_out), -2047);
        cycles(16395);
        chk("R6 reached zero", int'(q_out), 0);
        cycles(400);
        chk("R6 held at zero i", int'(i_out), 0);
        chk("R6 held at zero q", int'(q_out), 0);

        // R7: freeze below 3, resume at 3
        key_in = 1'b1; rate_word = 8'd3;
        do_reset();
        cycles(41);
        rate_word = 8'd1;
        cycles(50);
        chk("R7 frozen at rate 1", int'(q_out), -5);
        rate_word = 8'd2;
        cycles(30);
        chk("R7 frozen at rate 2", int'(q_out), -5);
        rate_word = 8'd3;
        cycles(20);
        chk("R7 resumes at rate 3", int'(q_out), -8);

        // R2: manual mode ignores the ramp and the key
        auto_mode = 1'b0; man_scale_i = 12'd2048; man_scale_q = 12'd1024;
        key_in = 1'b0;
        cycles(1);
        chk("R2 manual i ignores ramp", int'(i_out), 1023);
        chk("R2 manual q ignores ramp", int'(q_out), -512);

        finish_run();
    end

endmodule